// File: doc/BRIEF.md
# SPI Configuration Register Port

This block is the serial configuration slave of a mixed-signal device. A host reaches a file of thirty-two 8-bit configuration registers over a four-wire SPI link made of chip select, serial clock, data in and data out. The link is half duplex and framed in whole bytes. A command byte asks for a register write, which takes one data byte after it, for a register read, whose data comes back during the following byte, or for a device reset. The chip select may be tied low for good. In that case only the bit count frames the bytes.

All serial inputs pass through synchronizers into the system clock domain, and the block finds the serial clock edges there. The serial clock must therefore run below a quarter of the system clock. A watchdog counts system clock cycles while the serial clock is low. When it expires, it throws away a partial byte, so the next byte starts aligned. A serial clock that rests high never starts this watchdog. Reset comes from three places: a power-on reset, after which the device stays busy for a long count; an active-low reset input, which must be held low for at least two cycles; and the reset command. While the device is busy, all serial traffic is ignored and the register file is cleared.

Top module: `spi_cfg_port`

## Requirements
- R1: The opcode sits in the top three bits of a command byte and the register address in the low five bits. Opcode 001 takes the next byte as the new value of that register. Opcode 010 returns the register's value during the next byte. Every register holds 0 after any reset.
- R2: `din` is captured on rising edges of `sclk` and `dout` changes only after falling edges. Bytes travel MSB first. The first read bit appears after the falling edge that ends the read command byte.
- R3: While `csN` is high, the byte framing and the command state are held in reset, and two system clock cycles later `doutOe` is low. A partial byte followed by a rise of `csN` leaves no trace in later transfers.
- R4: With `csN` held low, any number of commands follow one another, framed by the bit count alone.
- R5: Command bytes with any other opcode, apart from the reset code 0x06, are ignored. Bytes received while read data is being sent out are never decoded as commands.
- R6: When `sclk` stays low for 2^TO_W system clock cycles, any partial byte is discarded and the next bit starts a new command byte.
- R7: When `sclk` rests high, the watchdog does not run, however long the pause. A byte split by such a pause is assembled intact.
- R8: When `rstN` is low for two or more cycles, the device is busy and its registers are cleared. Two cycles after `rstN` returns high, traffic is accepted again.
- R9: A low pulse on `rstN` that lasts only one cycle has no effect.
- R10: After `porN` is released, the device stays busy for 2^POR_W cycles, and a write sent in that window changes nothing.
- R11: The command byte 0x06 clears all registers and keeps the device busy for RST_HOLD cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstN | input | 1 | Reset/power-down request, active low, synchronous to clk |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| doutOe | output | 1 | Output enable for dout; low means high impedance |

## Verification
The traffic is framed in several ways: one command per select, many commands under one select, and select pulled in the middle of a byte. Together these show whether byte alignment comes from the bit count or from the select. Read values such as 0x80, 0x01, 0xA5 and 0xFF reveal bit order and off-by-one shifts. A read whose discarded input bytes look like a write command shows whether those bytes get decoded. Long low and long high pauses of the serial clock in the middle of a byte separate watchdog realignment from a wrongly armed watchdog. One-cycle and multi-cycle reset pulses, and writes sent during the power-on window, show when reset takes effect.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int BYTE_W    = 8;
  localparam int OP_W      = 3;
  localparam int ADDR_W    = BYTE_W - OP_W;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  localparam logic [OP_W-1:0]   OP_WRITE  = 3'b001;
  localparam logic [OP_W-1:0]   OP_READ   = 3'b010;
  localparam logic [BYTE_W-1:0] CMD_RESET = 8'h06;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_WDATA,
    ST_RDATA
  } frameSt_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic              capBit;  // shift in one received bit
    logic              wrReg;   // write received byte to register
    logic              ldOut;   // load read data into output shifter
    logic              shOut;   // present next output bit
    logic              clrOut;  // clear output path
    logic [ADDR_W-1:0] addr;    // register address for wrReg / ldOut
  } ctrlStrb_t;
endpackage

// File: rtl/spi_cfg_rstseq.sv
module spi_cfg_rstseq #(
  parameter int POR_W    = 16,
  parameter int RST_HOLD = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic rstN,
  input  logic rstCmd,
  output logic busy
);
  localparam int CNT_W = POR_W + 1;
  localparam logic [CNT_W-1:0] POR_LOAD  = {1'b1, {POR_W{1'b0}}};
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RST_HOLD);

  logic             rstLowQ;
  logic             armed;
  logic [CNT_W-1:0] holdCnt;

  // a qualified request is low in this cycle and the one before
  assign armed = ~rstN & rstLowQ;
  assign busy  = (holdCnt != '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstLowQ <= 1'b0;
      holdCnt <= POR_LOAD;
    end else begin
      rstLowQ <= ~rstN;
      if (armed || rstCmd) begin
        holdCnt <= HOLD_LOAD;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cfg_dp.sv
module spi_cfg_dp
  import spi_cfg_pkg::*;
#(
  parameter int TO_W = 18
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              busy,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  input  ctrlStrb_t         strb,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              csActive,
  output logic              toHit,
  output logic [BYTE_W-1:0] rxNext,
  output logic              dout,
  output logic              doutOe
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] sclkSy, csSy, dinSy;
  logic              sclkPrev;
  logic              sclkS, csS, dinS;
  logic [BYTE_W-1:0] rxSh;
  logic [BYTE_W-1:0] outSh;
  logic              doutQ;
  logic [TO_W-1:0]   toCnt;
  logic [BYTE_W-1:0] regFile [NUM_REGS];

  assign sclkS = sclkSy[SYNC_N-1];
  assign csS   = csSy[SYNC_N-1];
  assign dinS  = dinSy[SYNC_N-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sclkSy   <= '0;
      csSy     <= '1;
      dinSy    <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSy   <= {sclkSy[SYNC_N-2:0], sclk};
      csSy     <= {csSy[SYNC_N-2:0], csN};
      dinSy    <= {dinSy[SYNC_N-2:0], din};
      sclkPrev <= sclkS;
    end
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign csActive = ~csS;
  assign doutOe   = ~csS;
  assign dout     = doutQ;
  assign rxNext   = {rxSh[BYTE_W-2:0], dinS};

  // idle-low watchdog; a high serial clock keeps it cleared
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      toCnt <= '0;
    end else if (sclkS) begin
      toCnt <= '0;
    end else if (toCnt != {TO_W{1'b1}}) begin
      toCnt <= toCnt + 1'b1;
    end
  end
  assign toHit = ~sclkS & (toCnt == {TO_W{1'b1}});

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rxSh <= '0;
    end else if (strb.capBit) begin
      rxSh <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      outSh <= '0;
      doutQ <= 1'b0;
    end else if (strb.clrOut) begin
      outSh <= '0;
      doutQ <= 1'b0;
    end else if (strb.ldOut) begin
      outSh <= regFile[strb.addr];
    end else if (strb.shOut) begin
      doutQ <= outSh[BYTE_W-1];
      outSh <= {outSh[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (busy) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (strb.wrReg) begin
      regFile[strb.addr] <= rxNext;
    end
  end
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 busy,
  input  logic                 csActive,
  input  logic                 sclkRise,
  input  logic                 sclkFall,
  input  logic                 toHit,
  input  logic [BYTE_W-1:0]    rxNext,
  output ctrlStrb_t            strb,
  output logic                 rstCmd,
  output logic [BIT_CNT_W-1:0] bitCnt
);
  frameSt_e          state;
  logic [ADDR_W-1:0] addrQ;
  logic              frameRst;
  logic              byteEnd;
  logic [OP_W-1:0]   op;

  assign op = rxNext[BYTE_W-1 -: OP_W];

  always_comb begin
    frameRst    = busy | ~csActive | toHit;
    strb.capBit = ~frameRst & sclkRise;
    strb.shOut  = ~frameRst & sclkFall;
    strb.clrOut = frameRst;
    byteEnd     = strb.capBit & (bitCnt == BIT_CNT_W'(BYTE_W - 1));
    strb.wrReg  = byteEnd & (state == ST_WDATA);
    strb.ldOut  = byteEnd & (state == ST_CMD) & (op == OP_READ);
    rstCmd      = byteEnd & (state == ST_CMD) & (rxNext == CMD_RESET);
    strb.addr   = (state == ST_CMD) ? rxNext[ADDR_W-1:0] : addrQ;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state  <= ST_CMD;
      bitCnt <= '0;
      addrQ  <= '0;
    end else if (frameRst) begin
      state  <= ST_CMD;
      bitCnt <= '0;
    end else if (strb.capBit) begin
      bitCnt <= bitCnt + 1'b1;
      if (byteEnd) begin
        unique case (state)
          ST_CMD: begin
            if (op == OP_WRITE) begin
              state <= ST_WDATA;
              addrQ <= rxNext[ADDR_W-1:0];
            end else if (op == OP_READ) begin
              state <= ST_RDATA;
            end
          end
          ST_WDATA: state <= ST_CMD;
          ST_RDATA: state <= ST_CMD;
          default:  state <= ST_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int TO_W     = 18,
  parameter int POR_W    = 16,
  parameter int RST_HOLD = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic doutOe
);
  ctrlStrb_t            strb;
  logic                 busy;
  logic                 rstCmd;
  logic                 sclkRise;
  logic                 sclkFall;
  logic                 csActive;
  logic                 toHit;
  logic [BYTE_W-1:0]    rxNext;
  logic [BIT_CNT_W-1:0] bitCnt;

  spi_cfg_rstseq #(
    .POR_W   (POR_W),
    .RST_HOLD(RST_HOLD)
  ) u_rstseq (
    .clk   (clk),
    .porN  (porN),
    .rstN  (rstN),
    .rstCmd(rstCmd),
    .busy  (busy)
  );

  spi_cfg_ctrl u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .busy    (busy),
    .csActive(csActive),
    .sclkRise(sclkRise),
    .sclkFall(sclkFall),
    .toHit   (toHit),
    .rxNext  (rxNext),
    .strb    (strb),
    .rstCmd  (rstCmd),
    .bitCnt  (bitCnt)
  );

  spi_cfg_dp #(
    .TO_W(TO_W)
  ) u_dp (
    .clk     (clk),
    .porN    (porN),
    .busy    (busy),
    .sclk    (sclk),
    .csN     (csN),
    .din     (din),
    .strb    (strb),
    .sclkRise(sclkRise),
    .sclkFall(sclkFall),
    .csActive(csActive),
    .toHit   (toHit),
    .rxNext  (rxNext),
    .dout    (dout),
    .doutOe  (doutOe)
  );
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk (
  input logic       clk,
  input logic       porN,
  input logic       rstN,
  input logic       csN,
  input logic       doutOe,
  input logic       busy,
  input logic       wrReg,
  input logic       toHit,
  input logic [2:0] bitCnt
);
  // R3
  oe_off_chk: assert property (@(posedge clk) disable iff (!porN)
    (csN && $past(csN) && $past(csN, 2)) |-> !doutOe);

  // R6
  to_realign_chk: assert property (@(posedge clk) disable iff (!porN)
    toHit |=> (bitCnt == 3'd0));

  // R10
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!porN)
    busy |-> !wrReg);

  // R8
  pin_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!rstN && !$past(rstN)) |=> busy);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(busy) |-> ($past(rstN) && $past(rstN, 2)));

  // R9
  glitch_chk: assert property (@(posedge clk) disable iff (!porN)
    (rstN && !$past(rstN) && $past(rstN, 2) && !$past(busy)) |-> !busy);
endmodule

bind spi_cfg_port spi_cfg_chk u_chk (
  .clk   (clk),
  .porN  (porN),
  .rstN  (rstN),
  .csN   (csN),
  .doutOe(doutOe),
  .busy  (busy),
  .wrReg (strb.wrReg),
  .toHit (toHit),
  .bitCnt(bitCnt)
);

// File: tb/test_spi_cfg_port.sv
module test_spi_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int TO_W       = 9;
  localparam int POR_W      = 8;
  localparam int LONG_IDLE  = 600;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstN = 1'b1;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic dout, doutOe;

  int vecs = 0;
  int errs = 0;
  logic [7:0] model [32];
  logic h1 = 1'b1, h2 = 1'b1;
  logic [7:0] junk, rx;
  logic bitJunk;

  spi_cfg_port #(.TO_W(TO_W), .POR_W(POR_W), .RST_HOLD(2)) i_spi_cfg_port (
    .clk(clk), .porN(porN), .rstN(rstN), .csN(csN), .sclk(sclk),
    .din(din), .dout(dout), .doutOe(doutOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural model of the output enable: chip select seen two edges later (R3)
  always @(posedge clk) begin
    h1 <= csN;
    h2 <= h1;
  end
  always @(negedge clk) begin
    if (porN) begin
      vecs++;
      if (doutOe !== ~h2) begin
        errs++;
        $display("FAIL R3 doutOe act=%b exp=%b", doutOe, ~h2);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBit(input logic b, output logic r);
    @(negedge clk) din = b;
    waitClk(HALF);
    r = dout;
    sclk = 1'b1;
    waitClk(HALF);
    sclk = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spiBit(tx[i], r[i]);
  endtask

  task automatic csLow();
    @(negedge clk) csN = 1'b0;
    waitClk(4);
  endtask

  task automatic csHigh();
    waitClk(4);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    csLow();
    spiByte(8'h20 | 8'(a), junk);
    spiByte(d, junk);
    csHigh();
    model[a] = d;
  endtask

  task automatic checkReg(input string req, input logic [4:0] a);
    csLow();
    spiByte(8'h40 | 8'(a), junk);
    spiByte(8'h00, rx);
    csHigh();
    check(req, rx, model[a]);
  endtask

  task automatic clearModel();
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    clearModel();
    waitClk(3);
    porN = 1'b1;
    // R10: a write inside the power-on window is dropped
    csLow();
    spiByte(8'h23, junk);
    spiByte(8'h5A, junk);
    csHigh();
    waitClk(300);
    check("R3 reset dout", {7'd0, dout}, 8'h00);
    checkReg("R10", 5'd3);
    checkReg("R10", 5'd0);

    // R1 / R2: single commands per select, bit-order patterns
    wrReg(5'd5, 8'hA5);
    wrReg(5'd31, 8'h3C);
    wrReg(5'd0, 8'hFF);
    wrReg(5'd9, 8'h80);
    wrReg(5'd17, 8'h01);
    checkReg("R1", 5'd5);
    checkReg("R1", 5'd31);
    checkReg("R1", 5'd0);
    checkReg("R2", 5'd9);
    checkReg("R2", 5'd17);

    // R4: several commands under one select
    csLow();
    spiByte(8'h27, junk); spiByte(8'h96, junk); model[7] = 8'h96;
    spiByte(8'h47, junk); spiByte(8'h00, rx); check("R4", rx, 8'h96);
    spiByte(8'h28, junk); spiByte(8'h69, junk); model[8] = 8'h69;
    spiByte(8'h48, junk); spiByte(8'h00, rx); check("R4", rx, 8'h69);
    spiByte(8'h45, junk); spiByte(8'h00, rx); check("R4", rx, model[5]);
    csHigh();

    // R5: unknown opcodes ignored, then a write in the same frame
    csLow();
    spiByte(8'hFF, junk);
    spiByte(8'hE3, junk);
    spiByte(8'h00, junk);
    spiByte(8'h2B, junk); spiByte(8'hC3, junk); model[11] = 8'hC3;
    csHigh();
    checkReg("R5", 5'd11);
    // R5: a write-looking byte sent during read data is not decoded
    csLow();
    spiByte(8'h45, junk);
    spiByte(8'h2A, rx); check("R5", rx, model[5]);
    spiByte(8'h4B, junk);
    spiByte(8'h00, rx); check("R5", rx, model[11]);
    csHigh();
    checkReg("R5", 5'd10);

    // R3: partial byte aborted by chip select
    csLow();
    for (int i = 0; i < 5; i++) spiBit(1'b1, bitJunk);
    csHigh();
    wrReg(5'd12, 8'h77);
    checkReg("R3", 5'd12);

    // R6: partial byte then long idle-low realigns
    csLow();
    spiBit(1'b1, bitJunk); spiBit(1'b1, bitJunk); spiBit(1'b0, bitJunk);
    waitClk(LONG_IDLE);
    spiByte(8'h2D, junk); spiByte(8'h4E, junk); model[13] = 8'h4E;
    csHigh();
    checkReg("R6", 5'd13);

    // R7: command byte split by a long idle-high pause (0x2E = 0010_1110)
    csLow();
    spiBit(1'b0, bitJunk); spiBit(1'b0, bitJunk); spiBit(1'b1, bitJunk);
    @(negedge clk) din = 1'b0;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(LONG_IDLE);
    sclk = 1'b0;
    spiBit(1'b1, bitJunk); spiBit(1'b1, bitJunk); spiBit(1'b1, bitJunk); spiBit(1'b0, bitJunk);
    spiByte(8'hB1, junk); model[14] = 8'hB1;
    csHigh();
    checkReg("R7", 5'd14);

    // R9: single-cycle low pulse leaves registers alone
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    waitClk(5);
    checkReg("R9", 5'd5);
    checkReg("R9", 5'd31);

    // R8: qualified pin reset clears, traffic accepted two cycles after release
    @(negedge clk) rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    clearModel();
    waitClk(2);
    wrReg(5'd20, 8'h5E);
    checkReg("R8", 5'd20);
    checkReg("R8", 5'd5);
    checkReg("R8", 5'd31);

    // R11: reset command clears the file
    wrReg(5'd6, 8'h42);
    checkReg("R11", 5'd6);
    csLow();
    spiByte(8'h06, junk);
    csHigh();
    clearModel();
    checkReg("R11", 5'd6);
    checkReg("R11", 5'd20);
    wrReg(5'd6, 8'h24);
    checkReg("R11", 5'd6);

    finishRun();
  end
endmodule